// File: doc/BRIEF.md
# Batch Frozen VOQ Crossbar Scheduler

This block picks, once per time slot, which inputs of a four-port input-queued crossbar send a cell and to which output. Every input keeps one cell counter per output, so the counters form a 4x4 bipartite request graph. The scheduler only serves a frozen snapshot of these counters, called the current batch. Cells that arrive while that batch is being served go into a second set of counters, the next batch. The next batch is not served until the current batch has fully drained.

In each slot the block finds a matching of maximum size over the nonzero entries of the current batch. It gives each matched input one grant and decrements the matching counters. When the last cell of the batch is granted, the block raises a one-cycle done pulse, and the next batch replaces the current one. The block also reports the maximum port degree of the batch in service and the number of slots that batch has used so far, so the 2D completion bound can be observed from outside.

Top module: `batch_sched`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, grant_valid_o, batch_done_o, drop_o, degree_o and slots_o are all zero.
- R2: The granted inputs never share an output: for any two inputs a and b with grant_valid_o set, grant_dest_o[2a+1:2a] differs from grant_dest_o[2b+1:2b].
- R3: In every slot, the number of grants equals the size of a maximum matching over the current-batch VOQs with a nonzero count.
- R4: Among all permutations that reach the maximum size, the chosen permutation (dest of input 0, 1, 2, 3) is the lexicographically smallest. An input is granted only when its VOQ toward that permutation's output is nonzero.
- R5: Cells that arrive while the current batch is nonempty are counted in the next batch and are never granted before the current batch is empty. In any cycle where the current batch is empty, the next batch becomes the current batch at the clock edge, and the next batch restarts from zero plus that cycle's arrivals.
- R6: batch_done_o is high for exactly one cycle: the cycle after the grant that empties a nonempty current batch. No grant is issued in that cycle.
- R7: degree_o equals the largest row sum or column sum of the batch most recently loaded, and holds that value until the next load.
- R8: slots_o resets to zero on each load and counts the slots with at least one grant. While batch_done_o is high, slots_o is at most twice degree_o.
- R9: When every one of the 16 VOQs in a loaded batch holds the same nonzero count, slots_o equals degree_o while batch_done_o is high.
- R10: VOQ counts are 8 bits and saturate at 255. An arrival to a next-batch VOQ already at 255 is dropped, and drop_o[i] for that input is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arr_valid_i | input | 4 | Per-input cell arrival this slot |
| arr_dest_i | input | 8 | Per-input destination output, 2 bits per input |
| grant_valid_o | output | 4 | Input i sends a cell this slot |
| grant_dest_o | output | 8 | Output assigned to each input, 2 bits per input |
| batch_done_o | output | 1 | One-cycle pulse after a batch drains |
| drop_o | output | 4 | Arrival dropped on a saturated VOQ (previous cycle) |
| degree_o | output | 10 | Maximum port degree of the batch in service |
| slots_o | output | 11 | Slots with a grant since the batch was loaded |

## Verification
A directed batch with every VOQ set to one cell tests the exact-D completion of uniform batches, and a single-cell batch tests the shortest drain. Random light load produces sparse graphs where tie-breaking and partial matchings dominate. Near-full random load builds dense, uneven batches that exercise the 2D bound. A hotspot pattern, with all inputs sending to output 0, makes batches grow until VOQs saturate, which tests dropping and batch isolation under long service times.

// File: rtl/batch_sched_pkg.sv
package batch_sched_pkg;

  function automatic int unsigned fact(int unsigned n);
    int unsigned r;
    r = 1;
    for (int unsigned k = 2; k <= n; k++) r = r * k;
    return r;
  endfunction

  // Destination of input pos in the idx-th permutation, lexicographic order
  function automatic int unsigned perm_dest(int unsigned n, int unsigned idx, int unsigned pos);
    bit [31:0]   used;
    int unsigned rem, f, d, cnt, sel, res;
    used = '0;
    rem  = idx;
    res  = 0;
    for (int unsigned i = 0; i < n; i++) begin
      f   = fact(n - 1 - i);
      d   = rem / f;
      rem = rem % f;
      cnt = 0;
      sel = 0;
      for (int unsigned j = 0; j < n; j++) begin
        if (!used[j]) begin
          if (cnt == d) sel = j;
          cnt++;
        end
      end
      used[sel] = 1'b1;
      if (i == pos) res = sel;
    end
    return res;
  endfunction

endpackage

// File: rtl/batch_msm.sv
module batch_msm import batch_sched_pkg::*; #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N*N-1:0]  req_i,
  output logic [N-1:0]    gnt_valid_o,
  output logic [N*IW-1:0] gnt_dest_o
);
  localparam int unsigned NPERM = fact(N);
  localparam int unsigned PW    = (NPERM > 1) ? $clog2(NPERM) : 1;
  localparam int unsigned SW    = $clog2(N + 1);

  logic [N*IW-1:0] perm_tab [NPERM];
  logic [SW-1:0]   score    [NPERM];

  for (genvar p = 0; p < NPERM; p++) begin : g_perm
    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_in
      localparam int unsigned D = perm_dest(N, p, i);
      assign perm_tab[p][i*IW +: IW] = IW'(D);
      assign hit[i] = req_i[i*N + D];
    end
    assign score[p] = SW'($countones(hit));
  end

  logic [PW-1:0] best;
  logic [SW-1:0] best_s;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best   = '0;
    best_s = score[0];
    for (int p = 1; p < NPERM; p++) begin
      if (score[p] > best_s) begin
        best   = PW'(p);
        best_s = score[p];
      end
    end
  end

  always_comb begin
    gnt_dest_o = perm_tab[best];
    for (int i = 0; i < N; i++)
      gnt_valid_o[i] = req_i[i*N + int'(gnt_dest_o[i*IW +: IW])];
  end

endmodule

// File: rtl/batch_degree.sv
module batch_degree #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 8,
  parameter int unsigned DW = CW + $clog2(N)
) (
  input  logic [N*N*CW-1:0] cnt_i,
  output logic [DW-1:0]     max_o
);
  always_comb begin
    logic [DW-1:0] row_acc;
    logic [DW-1:0] col_acc;
    max_o = '0;
    for (int i = 0; i < N; i++) begin
      row_acc = '0;
      col_acc = '0;
      for (int j = 0; j < N; j++) begin
        row_acc = row_acc + DW'(cnt_i[(i*N+j)*CW +: CW]);
        col_acc = col_acc + DW'(cnt_i[(j*N+i)*CW +: CW]);
      end
      if (row_acc > max_o) max_o = row_acc;
      if (col_acc > max_o) max_o = col_acc;
    end
  end
endmodule

// File: rtl/batch_voq_store.sv
module batch_voq_store #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [N-1:0]      arr_valid_i,
  input  logic [N*IW-1:0]   arr_dest_i,
  input  logic [N-1:0]      gnt_valid_i,
  input  logic [N*IW-1:0]   gnt_dest_i,
  output logic [N*N-1:0]    req_o,
  output logic [N*N*CW-1:0] nxt_cnt_o,
  output logic              drained_o,
  output logic [N-1:0]      drop_o
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cur_q [N][N];
  logic [CW-1:0] nxt_q [N][N];
  logic [CW-1:0] cur_d [N][N];
  logic [CW-1:0] nxt_d [N][N];
  logic [N-1:0]  drop_d, drop_q;

  always_comb begin
    cur_d  = cur_q;
    nxt_d  = nxt_q;
    drop_d = '0;
    if (load_i) begin
      cur_d = nxt_q;
      nxt_d = '{default: '0};
    end else begin
      for (int i = 0; i < N; i++)
        if (gnt_valid_i[i])
          cur_d[i][gnt_dest_i[i*IW +: IW]] = cur_q[i][gnt_dest_i[i*IW +: IW]] - 1'b1;
    end
    for (int i = 0; i < N; i++) begin
      if (arr_valid_i[i]) begin
        if (nxt_d[i][arr_dest_i[i*IW +: IW]] == CMAX) drop_d[i] = 1'b1;
        else nxt_d[i][arr_dest_i[i*IW +: IW]] = nxt_d[i][arr_dest_i[i*IW +: IW]] + 1'b1;
      end
    end
  end

  always_comb begin
    drained_o = !load_i;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (cur_d[i][j] != '0) drained_o = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '{default: '0};
      nxt_q  <= '{default: '0};
      drop_q <= '0;
    end else begin
      cur_q  <= cur_d;
      nxt_q  <= nxt_d;
      drop_q <= drop_d;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      assign req_o[i*N+j]                = (cur_q[i][j] != '0);
      assign nxt_cnt_o[(i*N+j)*CW +: CW] = nxt_q[i][j];
    end
  end

  assign drop_o = drop_q;

endmodule

// File: rtl/batch_sched.sv
module batch_sched #(
  parameter int unsigned N   = 4,
  parameter int unsigned CW  = 8,
  parameter int unsigned IW  = $clog2(N),
  parameter int unsigned DW  = CW + $clog2(N),
  parameter int unsigned SLW = DW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    arr_valid_i,
  input  logic [N*IW-1:0] arr_dest_i,
  output logic [N-1:0]    grant_valid_o,
  output logic [N*IW-1:0] grant_dest_o,
  output logic            batch_done_o,
  output logic [N-1:0]    drop_o,
  output logic [DW-1:0]   degree_o,
  output logic [SLW-1:0]  slots_o
);
  logic [N*N-1:0]    req;
  logic [N*N*CW-1:0] nxt_cnt;
  logic [DW-1:0]     nxt_deg;
  logic              load, drained;
  logic              done_q;
  logic [DW-1:0]     deg_q;
  logic [SLW-1:0]    slots_q;

  assign load = ~|req;

  batch_voq_store #(.N(N), .CW(CW), .IW(IW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .arr_valid_i (arr_valid_i),
    .arr_dest_i  (arr_dest_i),
    .gnt_valid_i (grant_valid_o),
    .gnt_dest_i  (grant_dest_o),
    .req_o       (req),
    .nxt_cnt_o   (nxt_cnt),
    .drained_o   (drained),
    .drop_o      (drop_o)
  );

  batch_msm #(.N(N), .IW(IW)) u_msm (
    .req_i       (req),
    .gnt_valid_o (grant_valid_o),
    .gnt_dest_o  (grant_dest_o)
  );

  batch_degree #(.N(N), .CW(CW), .DW(DW)) u_deg (
    .cnt_i (nxt_cnt),
    .max_o (nxt_deg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      deg_q   <= '0;
      slots_q <= '0;
    end else begin
      done_q <= drained;
      if (load) begin
        deg_q   <= nxt_deg;
        slots_q <= '0;
      end else if (|grant_valid_o) begin
        slots_q <= slots_q + 1'b1;
      end
    end
  end

  assign batch_done_o = done_q;
  assign degree_o     = deg_q;
  assign slots_o      = slots_q;

endmodule

// File: rtl/batch_sched_chk.sv
module batch_sched_chk #(
  parameter int unsigned N   = 4,
  parameter int unsigned IW  = 2,
  parameter int unsigned DW  = 10,
  parameter int unsigned SLW = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N-1:0]    arr_valid_i,
  input logic [N-1:0]    grant_valid_o,
  input logic [N*IW-1:0] grant_dest_o,
  input logic            batch_done_o,
  input logic [N-1:0]    drop_o,
  input logic [DW-1:0]   degree_o,
  input logic [SLW-1:0]  slots_o
);
  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (grant_valid_o[a] && grant_valid_o[b] &&
            grant_dest_o[a*IW +: IW] == grant_dest_o[b*IW +: IW]) clash = 1'b1;
  end

  assert_grant_matching_R2: assert property (@(posedge clk_i) disable iff (!rst_ni) !clash);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batch_done_o |=> !batch_done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batch_done_o |-> grant_valid_o == '0);

  assert_slot_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    batch_done_o |-> slots_o <= {degree_o, 1'b0});

  assert_drop_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_o & ~$past(arr_valid_i)) == '0);

endmodule

bind batch_sched batch_sched_chk #(.N(N), .IW(IW), .DW(DW), .SLW(SLW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .arr_valid_i   (arr_valid_i),
  .grant_valid_o (grant_valid_o),
  .grant_dest_o  (grant_dest_o),
  .batch_done_o  (batch_done_o),
  .drop_o        (drop_o),
  .degree_o      (degree_o),
  .slots_o       (slots_o)
);

// File: tb/batch_sched_test.sv
module batch_sched_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  arr_valid_i = '0;
  logic [7:0]  arr_dest_i = '0;
  logic [3:0]  grant_valid_o;
  logic [7:0]  grant_dest_o;
  logic        batch_done_o;
  logic [3:0]  drop_o;
  logic [9:0]  degree_o;
  logic [10:0] slots_o;

  batch_sched uut (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, fails = 0;
  int m_cur [4][4];
  int m_nxt [4][4];
  int m_deg = 0, m_slots = 0;
  bit m_done = 0, m_uni = 0;
  bit [3:0] m_drop = '0;
  int uni_seen = 0, drop_seen = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int max_degree();
    int m = 0;
    for (int i = 0; i < 4; i++) begin
      int r = 0, c = 0;
      for (int j = 0; j < 4; j++) begin
        r += m_nxt[i][j];
        c += m_nxt[j][i];
      end
      if (r > m) m = r;
      if (c > m) m = c;
    end
    return m;
  endfunction

  task automatic step(logic [3:0] v, logic [7:0] d);
    int best = -1;
    int bp [4];
    bit [3:0] ev;
    bit empty, clash;
    @(negedge clk_i);
    // expected schedule: first lexicographic permutation of max score
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int e = 0; e < 4; e++) begin
            if (a != b && a != c && a != e && b != c && b != e && c != e) begin
              int s = int'(m_cur[0][a] > 0) + int'(m_cur[1][b] > 0) +
                      int'(m_cur[2][c] > 0) + int'(m_cur[3][e] > 0);
              if (s > best) begin
                best = s;
                bp = '{a, b, c, e};
              end
            end
          end
    for (int i = 0; i < 4; i++) ev[i] = m_cur[i][bp[i]] > 0;
    chk($countones(grant_valid_o) == best, "R3 grant count", $countones(grant_valid_o), best);
    chk(grant_valid_o == ev, "R4 grant vector", grant_valid_o, ev);
    clash = 0;
    for (int i = 0; i < 4; i++) begin
      if (grant_valid_o[i]) begin
        chk(int'(grant_dest_o[2*i +: 2]) == bp[i], "R4 grant dest", grant_dest_o[2*i +: 2], bp[i]);
        // R5: served cells must belong to the current batch
        chk(m_cur[i][grant_dest_o[2*i +: 2]] > 0, "R5 current batch only", 0, 1);
        for (int k = i + 1; k < 4; k++)
          if (grant_valid_o[k] && grant_dest_o[2*k +: 2] == grant_dest_o[2*i +: 2]) clash = 1;
      end
    end
    chk(!clash, "R2 distinct outputs", clash, 0);
    chk(batch_done_o == m_done, "R6 batch_done", batch_done_o, m_done);
    chk(drop_o == m_drop, "R10 drop", drop_o, m_drop);
    chk(int'(degree_o) == m_deg, "R7 degree", degree_o, m_deg);
    chk(int'(slots_o) == m_slots, "R8 slots", slots_o, m_slots);
    if (m_done) begin
      chk(int'(slots_o) <= 2 * int'(degree_o), "R8 2D bound", slots_o, 2 * degree_o);
      if (m_uni) begin
        uni_seen++;
        chk(slots_o == 11'(degree_o), "R9 uniform exact D", slots_o, degree_o);
      end
    end
    if (m_drop != 0) drop_seen++;
    // model advance
    empty = 1;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (m_cur[i][j] != 0) empty = 0;
    if (empty) begin
      m_deg = max_degree();
      m_uni = m_nxt[0][0] > 0;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          if (m_nxt[i][j] != m_nxt[0][0]) m_uni = 0;
          m_cur[i][j] = m_nxt[i][j];
          m_nxt[i][j] = 0;
        end
      m_slots = 0;
      m_done = 0;
    end else begin
      for (int i = 0; i < 4; i++) if (ev[i]) m_cur[i][bp[i]]--;
      if (ev != 0) m_slots++;
      m_done = 1;
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          if (m_cur[i][j] != 0) m_done = 0;
    end
    m_drop = '0;
    for (int i = 0; i < 4; i++) begin
      if (v[i]) begin
        if (m_nxt[i][d[2*i +: 2]] == 255) m_drop[i] = 1;
        else m_nxt[i][d[2*i +: 2]]++;
      end
    end
    arr_valid_i = v;
    arr_dest_i  = d;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        m_cur[i][j] = 0;
        m_nxt[i][j] = 0;
      end
    repeat (3) @(negedge clk_i);
    chk(grant_valid_o == 0 && batch_done_o == 0 && drop_o == 0, "R1 reset outputs", grant_valid_o, 0);
    chk(degree_o == 0 && slots_o == 0, "R1 reset stats", degree_o, 0);
    rst_ni = 1'b1;

    // uniform batch: primer to output 0, then one cell per VOQ
    step(4'hF, 8'h00);
    for (int c = 0; c < 4; c++) begin
      logic [7:0] d;
      for (int i = 0; i < 4; i++) d[2*i +: 2] = 2'((i + c) % 4);
      step(4'hF, d);
    end
    repeat (30) step(4'h0, 8'h00);

    // single cell batch
    step(4'b0100, 8'h30);
    repeat (10) step(4'h0, 8'h00);

    // light random load
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] v;
      for (int i = 0; i < 4; i++) v[i] = ($urandom % 10) < 3;
      step(v, 8'($urandom));
    end
    repeat (200) step(4'h0, 8'h00);

    // dense random load
    for (int n = 0; n < 2000; n++) begin
      logic [3:0] v;
      for (int i = 0; i < 4; i++) v[i] = ($urandom % 10) < 9;
      step(v, 8'($urandom));
    end
    repeat (3000) step(4'h0, 8'h00);

    // hotspot to output 0: batches grow until VOQs saturate
    repeat (600) step(4'hF, 8'h00);
    repeat (5000) step(4'h0, 8'h00);

    chk(uni_seen > 0, "R9 uniform batch observed", uni_seen, 1);
    chk(drop_seen > 0, "R10 saturation observed", drop_seen, 1);
    finish_run();
  end
endmodule